// File: doc/BRIEF.md
# Cross-Lane Ring Transfer Queue

This block carries single data words from each lane to the next lane up, in lane index order. It serves loops in which every iteration depends on a value produced by the iteration before it. Each lane has a send port toward its successor and a receive port from its predecessor. Every link between two neighbours holds one word and uses a valid/ready handshake, so a receiving lane waits until its predecessor has produced.

The ring is closed through a shared two-entry queue. The last active lane, at index `vl-1`, writes into the queue instead of a link, and lane 0 reads its incoming value from the head of the same queue. A control processor can push a seed into the queue before the first chunk of a stripmined loop, and can pop the value left after the last chunk. Between chunks, the value written by the last lane waits in the queue until lane 0 of the next chunk takes it.

The queue takes at most one write and one read per cycle. The lane wrap write beats a control push, and the lane 0 read beats a control pop.

Top module: `xlane_ring`

## Requirements
- R1: After synchronous reset, every `rcv_valid` bit and `cp_pop_valid` are low, and `cp_push_ready` is high.
- R2: For lane i with i+1 < vl, a send handshake on lane i makes `rcv_valid[i+1]` high after that clock edge, carrying the same data on `rcv_data[(i+1)*W +: W]`.
- R3: A link holds one word. While it is occupied, `snd_ready` of the sending lane is low, and the held word stays valid and unchanged until the receiving lane takes it.
- R4: The queue is first-in first-out. A send by lane vl-1 is written into it, and both lane 0 receive and the control pop are served from its head.
- R5: A control push writes its word into the queue. `cp_push_ready` is low whenever the queue holds QDEPTH (default 2) words.
- R6: When lane vl-1 offers a send in the same cycle as a control push, the lane wins: `cp_push_ready` is low in that cycle and the pushed word is not stored.
- R7: When lane 0 asserts `rcv_ready[0]` and the queue is not empty, `cp_pop_valid` is low, and lane 0 alone takes the head word.
- R8: While the queue is empty, `cp_pop_valid` and `rcv_valid[0]` are low, so no stale word is delivered.
- R9: Lanes with index >= vl are inactive. Their `snd_ready` and `rcv_valid` are low, and a send they offer changes no link and no queue entry.
- R10: Across consecutive chunks, lane 0 receives the word written by lane vl-1 in the chunk before, so a running value passes unchanged around the ring.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vl | input | $clog2(N+1) | Active lane count, 1..N; held steady while words are in flight |
| snd_valid | input | N | Per-lane send request toward the next lane |
| snd_data | input | N*W | Per-lane send word, lane i at bits i*W +: W |
| snd_ready | output | N | Per-lane send accepted this cycle |
| rcv_valid | output | N | Per-lane incoming word available |
| rcv_data | output | N*W | Per-lane incoming word, lane i at bits i*W +: W |
| rcv_ready | input | N | Per-lane receive request |
| cp_push_valid | input | 1 | Control processor seed push request |
| cp_push_data | input | W | Seed word |
| cp_push_ready | output | 1 | Seed push accepted this cycle |
| cp_pop_valid | output | 1 | Queue head offered to the control processor |
| cp_pop_data | output | W | Queue head word |
| cp_pop_ready | input | 1 | Control processor pop request |

## Verification
The queue has one write slot per cycle, and both the wrap send of lane vl-1 and a control push compete for it. The bench raises both requests in one cycle on an empty queue. It checks that `cp_push_ready` is low while the lane send is accepted, then pops and expects exactly the lane's word followed by an empty queue. The read side is provoked the same way: with one word queued, lane 0 and the control pop both request it. The bench expects the pop to be refused and lane 0 to receive the word, after which the queue is empty.

// File: rtl/xlane_ring_pkg.sv
package xlane_ring_pkg;

  // Role of a lane's send port for the current active lane count.
  typedef enum logic [1:0] {
    RT_LINK = 2'd0,  // feeds the link toward the next lane
    RT_WRAP = 2'd1,  // last active lane, feeds the shared queue
    RT_OFF  = 2'd2   // lane beyond the active count
  } route_e;

  function automatic route_e lane_route(input int lane, input int active);
    if (lane + 1 < active)       return RT_LINK;
    else if (lane + 1 == active) return RT_WRAP;
    else                         return RT_OFF;
  endfunction

endpackage

// File: rtl/xlane_link.sv
// One-word holding register between two neighbouring lanes.
module xlane_link #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         in_ready,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  input  logic         out_ready
);

  logic         full_q;
  logic [W-1:0] data_q;

  assign in_ready  = !full_q;
  assign out_valid = full_q;
  assign out_data  = data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (in_valid && !full_q) begin
      full_q <= 1'b1;
      data_q <= in_data;
    end else if (out_ready && full_q) begin
      full_q <= 1'b0;
    end
  end

endmodule

// File: rtl/xlane_seed_queue.sv
// Shared ring queue: lane wrap write beats control push,
// lane 0 read beats control pop. One write and one read per cycle.
module xlane_seed_queue #(
  parameter int W     = 8,
  parameter int DEPTH = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wa_valid,
  input  logic [W-1:0]                 wa_data,
  output logic                         wa_ready,
  input  logic                         wb_valid,
  input  logic [W-1:0]                 wb_data,
  output logic                         wb_ready,
  output logic                         ra_valid,
  input  logic                         ra_ready,
  output logic                         rb_valid,
  input  logic                         rb_ready,
  output logic [W-1:0]                 head_data,
  output logic [$clog2(DEPTH+1)-1:0]   count
);

  localparam int CW = $clog2(DEPTH + 1);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] count_q;
  logic          full, empty, do_wr, do_rd;
  logic [W-1:0]  wr_word;

  assign full  = (count_q == CW'(DEPTH));
  assign empty = (count_q == '0);

  assign wa_ready = !full;
  assign wb_ready = !full && !wa_valid;
  assign ra_valid = !empty;
  assign rb_valid = !empty && !ra_ready;

  assign do_wr   = (wa_valid && wa_ready) || (wb_valid && wb_ready);
  assign wr_word = wa_valid ? wa_data : wb_data;
  assign do_rd   = (ra_valid && ra_ready) || (rb_valid && rb_ready);

  assign head_data = mem[rptr_q];
  assign count     = count_q;

  // Storage without reset so it can map to distributed RAM.
  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr_q] <= wr_word;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      count_q <= '0;
    end else begin
      if (do_wr) wptr_q <= (wptr_q == LAST) ? '0 : wptr_q + 1'b1;
      if (do_rd) rptr_q <= (rptr_q == LAST) ? '0 : rptr_q + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

endmodule

// File: rtl/xlane_ring.sv
module xlane_ring #(
  parameter int N      = 4,
  parameter int W      = 8,
  parameter int QDEPTH = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [$clog2(N+1)-1:0]   vl,
  input  logic [N-1:0]             snd_valid,
  input  logic [N*W-1:0]           snd_data,
  output logic [N-1:0]             snd_ready,
  output logic [N-1:0]             rcv_valid,
  output logic [N*W-1:0]           rcv_data,
  input  logic [N-1:0]             rcv_ready,
  input  logic                     cp_push_valid,
  input  logic [W-1:0]             cp_push_data,
  output logic                     cp_push_ready,
  output logic                     cp_pop_valid,
  output logic [W-1:0]             cp_pop_data,
  input  logic                     cp_pop_ready
);

  import xlane_ring_pkg::*;

  localparam int LINKS = N - 1;
  localparam int QCW   = $clog2(QDEPTH + 1);

  route_e             rt [N];
  logic [LINKS-1:0]   lk_in_valid, lk_in_ready, lk_out_valid, lk_out_ready;
  logic [W-1:0]       lk_out_data [LINKS];
  logic               wrap_valid, wrap_ready;
  logic [W-1:0]       wrap_data;
  logic               lane0_on, q_ra_valid, q_ra_ready;
  logic [W-1:0]       q_head;
  logic [QCW-1:0]     q_count;

  always_comb begin
    for (int i = 0; i < N; i++) rt[i] = lane_route(i, int'(vl));
  end

  // Send side: pick the wrap lane and steer each lane's handshake.
  always_comb begin
    wrap_valid = 1'b0;
    wrap_data  = '0;
    for (int i = 0; i < N; i++) begin
      if (rt[i] == RT_WRAP) begin
        wrap_valid = snd_valid[i];
        wrap_data  = snd_data[i*W +: W];
      end
    end
  end

  generate
    for (genvar g = 0; g < N; g++) begin : g_send
      if (g < LINKS) begin : g_lk
        assign lk_in_valid[g] = snd_valid[g] && (rt[g] == RT_LINK);
        assign snd_ready[g]   = (rt[g] == RT_LINK) ? lk_in_ready[g] :
                                (rt[g] == RT_WRAP) ? wrap_ready : 1'b0;
      end else begin : g_top
        assign snd_ready[g] = (rt[g] == RT_WRAP) ? wrap_ready : 1'b0;
      end
    end

    for (genvar g = 0; g < LINKS; g++) begin : g_link
      xlane_link #(.W(W)) u_link (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (lk_in_valid[g]),
        .in_data   (snd_data[g*W +: W]),
        .in_ready  (lk_in_ready[g]),
        .out_valid (lk_out_valid[g]),
        .out_data  (lk_out_data[g]),
        .out_ready (lk_out_ready[g])
      );
    end

    // Receive side: lane 0 from the queue head, others from their link.
    for (genvar g = 1; g < N; g++) begin : g_rcv
      logic on;
      assign on                 = (rt[g] != RT_OFF);
      assign rcv_valid[g]       = on && lk_out_valid[g-1];
      assign rcv_data[g*W +: W] = lk_out_data[g-1];
      assign lk_out_ready[g-1]  = on && rcv_ready[g];
    end
  endgenerate

  assign lane0_on       = (rt[0] != RT_OFF);
  assign q_ra_ready     = lane0_on && rcv_ready[0];
  assign rcv_valid[0]   = lane0_on && q_ra_valid;
  assign rcv_data[0 +: W] = q_head;
  assign cp_pop_data    = q_head;

  xlane_seed_queue #(.W(W), .DEPTH(QDEPTH)) u_queue (
    .clk       (clk),
    .rst       (rst),
    .wa_valid  (wrap_valid),
    .wa_data   (wrap_data),
    .wa_ready  (wrap_ready),
    .wb_valid  (cp_push_valid),
    .wb_data   (cp_push_data),
    .wb_ready  (cp_push_ready),
    .ra_valid  (q_ra_valid),
    .ra_ready  (q_ra_ready),
    .rb_valid  (cp_pop_valid),
    .rb_ready  (cp_pop_ready),
    .head_data (q_head),
    .count     (q_count)
  );

endmodule

// File: rtl/xlane_ring_chk.sv
module xlane_ring_chk #(
  parameter int N      = 4,
  parameter int W      = 8,
  parameter int QDEPTH = 2
) (
  input logic                          clk,
  input logic                          rst,
  input logic [$clog2(N+1)-1:0]        vl,
  input logic [N-1:0]                  snd_valid,
  input logic [N-1:0]                  snd_ready,
  input logic [N-1:0]                  rcv_valid,
  input logic [N*W-1:0]                rcv_data,
  input logic [N-1:0]                  rcv_ready,
  input logic                          cp_push_ready,
  input logic                          cp_pop_valid,
  input logic [$clog2(QDEPTH+1)-1:0]   q_count
);

  localparam int VW  = $clog2(N + 1);
  localparam int QCW = $clog2(QDEPTH + 1);

  logic wrap_req;
  always_comb begin
    wrap_req = 1'b0;
    for (int i = 0; i < N; i++)
      if (VW'(i + 1) == vl && snd_valid[i]) wrap_req = 1'b1;
  end

  p_full_blocks_push_r5: assert property (@(posedge clk) disable iff (rst)
    (q_count == QCW'(QDEPTH)) |-> !cp_push_ready);

  p_wrap_wins_r6: assert property (@(posedge clk) disable iff (rst)
    wrap_req |-> !cp_push_ready);

  p_lane0_first_r7: assert property (@(posedge clk) disable iff (rst)
    rcv_ready[0] |-> !cp_pop_valid);

  p_no_stale_r8: assert property (@(posedge clk) disable iff (rst)
    (q_count == '0) |-> (!cp_pop_valid && !rcv_valid[0]));

  generate
    for (genvar g = 0; g < N; g++) begin : g_lane
      p_inactive_r9: assert property (@(posedge clk) disable iff (rst)
        (vl <= VW'(g)) |-> (!snd_ready[g] && !rcv_valid[g]));
    end
    for (genvar g = 1; g < N; g++) begin : g_hold
      p_link_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (rcv_valid[g] && !rcv_ready[g]) |=>
          ($stable(vl) -> (rcv_valid[g] && $stable(rcv_data[g*W +: W]))));
    end
  endgenerate

endmodule

bind xlane_ring xlane_ring_chk #(.N(N), .W(W), .QDEPTH(QDEPTH)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .vl            (vl),
  .snd_valid     (snd_valid),
  .snd_ready     (snd_ready),
  .rcv_valid     (rcv_valid),
  .rcv_data      (rcv_data),
  .rcv_ready     (rcv_ready),
  .cp_push_ready (cp_push_ready),
  .cp_pop_valid  (cp_pop_valid),
  .q_count       (q_count)
);

// File: tb/xlane_ring_bench.sv
module xlane_ring_bench;
  localparam int N  = 4;
  localparam int W  = 8;
  localparam int QD = 2;
  localparam int VW = $clog2(N + 1);

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [VW-1:0]  vl = VW'(N);
  logic [N-1:0]   snd_valid = '0;
  logic [N*W-1:0] snd_data = '0;
  logic [N-1:0]   snd_ready;
  logic [N-1:0]   rcv_valid;
  logic [N*W-1:0] rcv_data;
  logic [N-1:0]   rcv_ready = '0;
  logic           cp_push_valid = 1'b0;
  logic [W-1:0]   cp_push_data = '0;
  logic           cp_push_ready;
  logic           cp_pop_valid;
  logic [W-1:0]   cp_pop_data;
  logic           cp_pop_ready = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  xlane_ring #(.N(N), .W(W), .QDEPTH(QD)) u_xlane_ring (
    .clk(clk), .rst(rst), .vl(vl),
    .snd_valid(snd_valid), .snd_data(snd_data), .snd_ready(snd_ready),
    .rcv_valid(rcv_valid), .rcv_data(rcv_data), .rcv_ready(rcv_ready),
    .cp_push_valid(cp_push_valid), .cp_push_data(cp_push_data),
    .cp_push_ready(cp_push_ready),
    .cp_pop_valid(cp_pop_valid), .cp_pop_data(cp_pop_data),
    .cp_pop_ready(cp_pop_ready)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Lane i takes its incoming word, which must equal exp.
  task automatic lane_recv(input int i, input logic [W-1:0] exp, input string req);
    @(negedge clk);
    rcv_ready[i] = 1'b1;
    #1;
    chk(rcv_valid[i] == 1'b1, req, rcv_valid[i], 1);
    chk(rcv_data[i*W +: W] == exp, req, rcv_data[i*W +: W], exp);
    @(posedge clk); #1;
    rcv_ready[i] = 1'b0;
  endtask

  task automatic lane_send(input int i, input logic [W-1:0] d, input string req);
    @(negedge clk);
    snd_valid[i] = 1'b1;
    snd_data[i*W +: W] = d;
    #1;
    chk(snd_ready[i] == 1'b1, req, snd_ready[i], 1);
    @(posedge clk); #1;
    snd_valid[i] = 1'b0;
  endtask

  task automatic cp_push(input logic [W-1:0] d, input string req);
    @(negedge clk);
    cp_push_valid = 1'b1;
    cp_push_data  = d;
    #1;
    chk(cp_push_ready == 1'b1, req, cp_push_ready, 1);
    @(posedge clk); #1;
    cp_push_valid = 1'b0;
  endtask

  task automatic cp_pop(input logic [W-1:0] exp, input string req);
    @(negedge clk);
    cp_pop_ready = 1'b1;
    #1;
    chk(cp_pop_valid == 1'b1, req, cp_pop_valid, 1);
    chk(cp_pop_data == exp, req, cp_pop_data, exp);
    @(posedge clk); #1;
    cp_pop_ready = 1'b0;
  endtask

  task automatic expect_empty(input string req);
    @(negedge clk); #1;
    chk(cp_pop_valid == 1'b0, req, cp_pop_valid, 0);
    chk(rcv_valid[0] == 1'b0, req, rcv_valid[0], 0);
  endtask

  initial begin
    logic [W-1:0] acc;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R1: reset state
    chk(rcv_valid == '0, "R1", rcv_valid, 0);
    chk(cp_pop_valid == 1'b0, "R1", cp_pop_valid, 0);
    chk(cp_push_ready == 1'b1, "R1", cp_push_ready, 1);

    // Sweep every active lane count with two chunks each (R2, R4, R10, R9)
    for (int v = 1; v <= N; v++) begin
      @(negedge clk);
      vl = VW'(v);
      #1;
      for (int k = v; k < N; k++) begin
        chk(snd_ready[k] == 1'b0, "R9", snd_ready[k], 0);
        chk(rcv_valid[k] == 1'b0, "R9", rcv_valid[k], 0);
      end
      acc = W'(8'h10 * v + 3);
      cp_push(acc, "R5");
      for (int c = 0; c < 2; c++) begin
        for (int i = 0; i < v; i++) begin
          lane_recv(i, acc, (i == 0) ? ((c == 0) ? "R4" : "R10") : "R2");
          acc = acc + W'(i + 1 + 7 * c);
          lane_send(i, acc, (i == v - 1) ? "R4" : "R2");
        end
      end
      cp_pop(acc, "R4");
      expect_empty("R8");
    end

    // R3: occupied link refuses a second word and holds the first
    @(negedge clk); vl = VW'(N);
    lane_send(0, 8'hA5, "R2");
    @(negedge clk);
    snd_valid[0] = 1'b1;
    snd_data[0 +: W] = 8'h5A;
    #1;
    chk(snd_ready[0] == 1'b0, "R3", snd_ready[0], 0);
    @(posedge clk); #1;
    snd_valid[0] = 1'b0;
    @(negedge clk); #1;
    chk(rcv_data[W +: W] == 8'hA5, "R3", rcv_data[W +: W], 8'hA5);
    lane_recv(1, 8'hA5, "R3");
    @(negedge clk); #1;
    chk(rcv_valid[1] == 1'b0, "R3", rcv_valid[1], 0);

    // R5: two pushes fill the queue; R4: popped in order
    cp_push(8'h11, "R5");
    cp_push(8'h22, "R5");
    @(negedge clk);
    cp_push_valid = 1'b1;
    cp_push_data  = 8'h33;
    #1;
    chk(cp_push_ready == 1'b0, "R5", cp_push_ready, 0);
    @(posedge clk); #1;
    cp_push_valid = 1'b0;
    cp_pop(8'h11, "R4");
    cp_pop(8'h22, "R4");
    expect_empty("R5");

    // R6: wrap send and control push in the same cycle
    @(negedge clk);
    vl = VW'(2);
    snd_valid[1] = 1'b1;
    snd_data[W +: W] = 8'h3C;
    cp_push_valid = 1'b1;
    cp_push_data  = 8'h44;
    #1;
    chk(cp_push_ready == 1'b0, "R6", cp_push_ready, 0);
    chk(snd_ready[1] == 1'b1, "R6", snd_ready[1], 1);
    @(posedge clk); #1;
    snd_valid[1] = 1'b0;
    cp_push_valid = 1'b0;
    cp_pop(8'h3C, "R6");
    expect_empty("R6");

    // R7: lane 0 receive and control pop in the same cycle
    cp_push(8'h77, "R7");
    @(negedge clk);
    rcv_ready[0] = 1'b1;
    cp_pop_ready = 1'b1;
    #1;
    chk(cp_pop_valid == 1'b0, "R7", cp_pop_valid, 0);
    chk(rcv_valid[0] == 1'b1, "R7", rcv_valid[0], 1);
    chk(rcv_data[0 +: W] == 8'h77, "R7", rcv_data[0 +: W], 8'h77);
    @(posedge clk); #1;
    rcv_ready[0] = 1'b0;
    cp_pop_ready = 1'b0;
    expect_empty("R7");

    // R9: sends from inactive lanes are ignored
    @(negedge clk);
    snd_valid[3] = 1'b1;
    snd_valid[2] = 1'b1;
    snd_data[3*W +: W] = 8'h99;
    #1;
    chk(snd_ready[3] == 1'b0, "R9", snd_ready[3], 0);
    chk(snd_ready[2] == 1'b0, "R9", snd_ready[2], 0);
    @(posedge clk); #1;
    snd_valid = '0;
    @(negedge clk); #1;
    chk(rcv_valid == '0, "R9", rcv_valid, 0);
    chk(cp_pop_valid == 1'b0, "R9", cp_pop_valid, 0);
    @(negedge clk); vl = VW'(N);
    #1;
    chk(rcv_valid == '0, "R9", rcv_valid, 0);

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule